// File: doc/BRIEF.md
# Pipelined Fixed-to-Float Converter

This block turns a stream of two's-complement fixed-point samples, such as the words coming from an ADC front end, into a floating-point format. The format has a sign bit, an exponent field and a mantissa field. The mantissa is stored explicitly as 0.f, so a normalized nonzero value always has its top mantissa bit set. The value of a word is (-1)^sign × 0.f × 2^(exp − bias). Four parameters set the sizes: the sample width, how many of its bits are fractional, the exponent width and the mantissa width.

A sample and its valid flag enter together, and the converted word leaves two clock cycles later with its own valid flag. The first stage forms the absolute value and flags an all-zero input. The second stage finds the leading one, computes the exponent from its position, shifts the magnitude into place and rounds away the low bits that do not fit. Rounding is to nearest, with ties going to even. A zero input skips the arithmetic and produces fixed constants.

Top module: `fx2fp_conv`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and float_o is all zeros.
- R2: For a nonzero sample, float_o bit [EXP_W+MAN_W] (the sign) equals the sample's MSB.
- R3: A zero sample yields an all-zero float_o (sign, exponent and mantissa all 0).
- R4: float_o is packed as {sign, exponent[EXP_W-1:0], mantissa[MAN_W-1:0]}. For a nonzero sample with magnitude leading one at bit k (bit 0 is the LSB), and no rounding carry, the exponent is k + 1 + bias − FRAC_W, where bias = 2^(EXP_W−1) − 1.
- R5: The most negative sample −2^(FIX_W−1) is treated as the magnitude 2^(FIX_W−1). Its exponent is bias + FIX_W − FRAC_W and its mantissa is 1 followed by zeros.
- R6: For a nonzero sample, mantissa bit MAN_W−1 is 1. When the magnitude has at most MAN_W significant bits, the mantissa is the magnitude shifted left with zero fill.
- R7: When the magnitude has more than MAN_W significant bits, the dropped bits are rounded to nearest, ties to even. A dropped part above one half rounds up, a part below one half rounds down, and an exact half rounds up only if the kept LSB is 1.
- R8: When rounding carries out of the mantissa, the mantissa becomes 1 followed by zeros and the exponent is one more than R4 gives.
- R9: valid_o equals valid_i from two clock cycles earlier. float_o in that cycle is the result for the sample presented with it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample valid |
| fix_i | input | FIX_W | Two's-complement fixed-point sample |
| valid_o | output | 1 | Result valid, two cycles after valid_i |
| float_o | output | 1+EXP_W+MAN_W | Floating-point result {sign, exponent, mantissa} |

## Verification
The block keeps no state beyond two pipeline stages, so any internal error shows at the ports exactly two cycles after the sample that caused it. A wrong leading-one position appears as an exponent that is off by the position error. It also appears as a mantissa whose top bit is clear, or whose bits are misaligned. A rounding fault shows only on samples wider than the mantissa, either as a result one unit off at a tie or as a missed exponent increment on carry. For these reasons every sample code of a small configuration is streamed through the block with gaps in valid. Each result is compared with an arithmetic model.

// File: rtl/fx2fp_pkg.sv
package fx2fp_pkg;
  function automatic int exp_bias(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction
endpackage

// File: rtl/fx2fp_abs.sv
module fx2fp_abs #(
  parameter int FIX_W = 12
) (
  input  logic [FIX_W-1:0] fix_i,
  output logic [FIX_W-1:0] mag_o,
  output logic             sign_o,
  output logic             zero_o
);
  // most negative input stays 100..0, read as unsigned 2^(FIX_W-1)
  assign sign_o = fix_i[FIX_W-1];
  assign mag_o  = sign_o ? (~fix_i + 1'b1) : fix_i;
  assign zero_o = ~|fix_i;
endmodule

// File: rtl/fx2fp_lead_one.sv
module fx2fp_lead_one #(
  parameter int W     = 12,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic [POS_W-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++)
      if (vec_i[i]) pos_o = POS_W'(i);
  end
endmodule

// File: rtl/fx2fp_norm_round.sv
module fx2fp_norm_round #(
  parameter int FIX_W = 12,
  parameter int MAN_W = 8,
  parameter int POS_W = $clog2(FIX_W)
) (
  input  logic [FIX_W-1:0] mag_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [MAN_W-1:0] man_o,
  output logic             carry_o
);
  localparam logic [POS_W-1:0] TOP = POS_W'(FIX_W - 1);

  logic [FIX_W-1:0] norm;
  assign norm = mag_i << (TOP - pos_i);

  generate
    if (FIX_W > MAN_W) begin : g_round
      localparam int DROP = FIX_W - MAN_W;
      logic [MAN_W-1:0] kept;
      logic             guard, sticky, inc;
      logic [MAN_W:0]   sum;
      assign kept  = norm[FIX_W-1 -: MAN_W];
      assign guard = norm[DROP-1];
      if (DROP > 1) begin : g_sticky
        assign sticky = |norm[DROP-2:0];
      end else begin : g_nosticky
        assign sticky = 1'b0;
      end
      assign inc     = guard & (sticky | kept[0]);
      assign sum     = {1'b0, kept} + {{MAN_W{1'b0}}, inc};
      assign carry_o = sum[MAN_W];
      assign man_o   = carry_o ? {1'b1, {(MAN_W-1){1'b0}}} : sum[MAN_W-1:0];
    end else begin : g_pad
      assign man_o   = MAN_W'(norm) << (MAN_W - FIX_W);
      assign carry_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fx2fp_conv.sv
module fx2fp_conv
  import fx2fp_pkg::*;
#(
  parameter int FIX_W  = 12,
  parameter int FRAC_W = 4,
  parameter int EXP_W  = 6,
  parameter int MAN_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic [FIX_W-1:0]       fix_i,
  output logic                   valid_o,
  output logic [EXP_W+MAN_W:0]   float_o
);
  localparam int POS_W = $clog2(FIX_W);
  localparam int EOFF  = exp_bias(EXP_W) + 1 - FRAC_W;
  localparam logic [EXP_W-1:0] ZERO_EXP = '0;
  localparam logic [MAN_W-1:0] ZERO_MAN = '0;

  // stage 1: absolute value, zero detect
  logic [FIX_W-1:0] mag_d, s1_mag;
  logic             sign_d, zero_d, s1_sign, s1_zero, s1_vld;

  fx2fp_abs #(.FIX_W(FIX_W)) u_abs (
    .fix_i  (fix_i),
    .mag_o  (mag_d),
    .sign_o (sign_d),
    .zero_o (zero_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_sign <= 1'b0;
      s1_zero <= 1'b1;
      s1_mag  <= '0;
    end else begin
      s1_vld  <= valid_i;
      s1_sign <= sign_d;
      s1_zero <= zero_d;
      s1_mag  <= mag_d;
    end
  end

  // stage 2: leading one, normalize, round, exponent
  logic [POS_W-1:0]   pos;
  logic [MAN_W-1:0]   man_d;
  logic               carry;
  logic [EXP_W-1:0]   exp_d;
  logic [EXP_W+MAN_W:0] word_d;

  fx2fp_lead_one #(.W(FIX_W), .POS_W(POS_W)) u_lead (
    .vec_i (s1_mag),
    .pos_o (pos)
  );

  fx2fp_norm_round #(.FIX_W(FIX_W), .MAN_W(MAN_W), .POS_W(POS_W)) u_norm (
    .mag_i   (s1_mag),
    .pos_i   (pos),
    .man_o   (man_d),
    .carry_o (carry)
  );

  assign exp_d  = EXP_W'(EOFF) + EXP_W'(pos) + EXP_W'(carry);
  assign word_d = s1_zero ? {1'b0, ZERO_EXP, ZERO_MAN} : {s1_sign, exp_d, man_d};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      float_o <= '0;
    end else begin
      valid_o <= s1_vld;
      float_o <= word_d;
    end
  end
endmodule

// File: rtl/fx2fp_conv_chk.sv
module fx2fp_conv_chk #(
  parameter int FIX_W  = 12,
  parameter int FRAC_W = 4,
  parameter int EXP_W  = 6,
  parameter int MAN_W  = 8
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic [FIX_W-1:0]     fix_i,
  input logic                 valid_o,
  input logic [EXP_W+MAN_W:0] float_o
);
  localparam logic [FIX_W-1:0] MOST_NEG = {1'b1, {(FIX_W-1){1'b0}}};
  logic [1:0] age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2) |-> (valid_o == $past(valid_i, 2)));

  p_zero_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && $past(fix_i, 2) == '0) |-> (float_o == '0));

  p_sign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && $past(fix_i, 2) != '0) |->
      (float_o[EXP_W+MAN_W] == $past(fix_i[FIX_W-1], 2)));

  p_norm_msb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && $past(fix_i, 2) != '0) |-> float_o[MAN_W-1]);

  p_most_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd2 && $past(fix_i, 2) == MOST_NEG) |->
      (float_o[MAN_W-1:0] == {1'b1, {(MAN_W-1){1'b0}}}));

  always @(posedge clk_i)
    if (!rst_ni) p_reset_r1: assert (!valid_o && float_o == '0);
endmodule

bind fx2fp_conv fx2fp_conv_chk #(
  .FIX_W(FIX_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MAN_W(MAN_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .fix_i   (fix_i),
  .valid_o (valid_o),
  .float_o (float_o)
);

// File: tb/fx2fp_conv_test.sv
`timescale 1ns/1ps
module fx2fp_conv_test;
  localparam int FIX_W  = 12;
  localparam int FRAC_W = 4;
  localparam int EXP_W  = 6;
  localparam int MAN_W  = 8;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int OW     = 1 + EXP_W + MAN_W;
  localparam int N      = 1 << FIX_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [FIX_W-1:0] fix_i = '0;
  logic valid_o;
  logic [OW-1:0] float_o;

  int tests = 0;
  int fails = 0;
  logic [OW-1:0] exp_w [0:N-1];
  string         exp_t [0:N-1];
  logic          exp_v [0:N-1];

  always #4 clk_i = ~clk_i;

  fx2fp_conv #(.FIX_W(FIX_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .fix_i(fix_i),
    .valid_o(valid_o), .float_o(float_o)
  );

  task automatic check(input string req, input logic [OW-1:0] act, input logic [OW-1:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // arithmetic model of R2..R8
  task automatic model(input int raw, output logic [OW-1:0] w, output string tag);
    int v, m, k, e, man, sh, rem, half;
    bit s;
    v = (raw >= N/2) ? raw - N : raw;
    s = v < 0;
    m = s ? -v : v;
    tag = "R4";
    if (m == 0) begin
      w = '0; tag = "R3";
      return;
    end
    k = 0;
    for (int j = 0; j < FIX_W; j++) if ((m >> j) & 1) k = j;
    e = k + 1 + BIAS - FRAC_W;
    if (k + 1 > MAN_W) begin
      sh = k + 1 - MAN_W;
      man = m >> sh;
      rem = m & ((1 << sh) - 1);
      half = 1 << (sh - 1);
      if (rem > half || (rem == half && (man % 2) == 1)) man++;
      if (man == (1 << MAN_W)) begin
        man = 1 << (MAN_W - 1); e++; tag = "R8";
      end else if (rem != 0) tag = "R7";
    end else begin
      man = m << (MAN_W - k - 1);
      tag = "R6";
    end
    if (raw == N/2) tag = "R5";
    w = {s, EXP_W'(e), MAN_W'(man)};
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset", {valid_o, float_o}, '0);
    rst_ni = 1'b1;
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk_i);
      if (i >= 2) begin
        logic [OW-1:0] e;
        e = exp_w[i-2];
        check("R9 valid", OW'(valid_o), OW'(exp_v[i-2]));
        check(exp_t[i-2], float_o, e);
        if (e != '0) begin
          check("R2 sign", OW'(float_o[OW-1]), OW'((i - 2) >= N/2));
          check("R6 msb", OW'(float_o[MAN_W-1]), OW'(1));
        end
      end
      if (i < N) begin
        logic [OW-1:0] w;
        string t;
        model(i, w, t);
        exp_w[i] = w; exp_t[i] = t;
        exp_v[i] = (i % 7) != 3;
        fix_i = FIX_W'(i);
        valid_i = exp_v[i];
      end else begin
        valid_i = 1'b0;
        fix_i = '0;
      end
    end
    repeat (3) @(negedge clk_i);
    check("R9 idle", OW'(valid_o), OW'(0));
    check("R3 idle zero", float_o, '0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule